// File: doc/BRIEF.md
# I2C Read-Only Slave with Clock Stretching

This block is an I2C slave that answers only read requests. It recognises a 7-bit address set by a configuration input. The two bus lines are oversampled on the system clock through a synchronizer, and an edge stage finds START, STOP and the rising and falling edges of SCL. When a read request matches the address, the block acknowledges it, stores the received address byte in its data buffer and raises a per-byte interrupt flag. It then pulls SCL low until the host side has supplied the next byte.

The host side sees a simple register-style interface: a write strobe for the transmit buffer, a strobe that releases the clock, a read strobe with the buffer contents, a sticky interrupt flag with a clear strobe, and two status bits (read direction, buffer full). The host may release the clock only after it has written a fresh byte. Each byte goes out MSB first. The master's acknowledge decides what happens next: on ACK the block stretches the clock again, and on NACK it goes back to waiting for a START. Both bus outputs are active-high pull-low enables for open-drain pads.

Top module: `i2cs_top`

## Requirements
- R1: After reset both pull-low enables are 0, the interrupt flag is 0, and both status bits are 0.
- R2: A START followed by a byte whose upper 7 bits equal `own_addr` and whose LSB (R/W) is 1 is acknowledged by pulling SDA low during the ninth clock. At that point `stat_rw` becomes 1, the whole byte (address in bits 7:1, R/W in bit 0) appears on `buf_rdata`, and `stat_full` becomes 1.
- R3: After the falling edge of the ninth clock of an acknowledged address byte or of an ACKed data byte, `irq_flag` becomes 1 and `scl_oe` stays 1 (clock stretched). While SCL is stretched, `sda_oe` is 0.
- R4: A `rel_set` pulse while the clock is stretched has no effect unless `txbuf_wr` was pulsed since the clock was last stretched. In that case `scl_oe` remains 1.
- R5: After a buffer write, `rel_set` drops `scl_oe`. The written byte is then sent MSB first, with each bit changed only after a falling edge of SCL.
- R6: If the master drives SDA low at the ninth rising edge after a data byte (ACK), the block stretches the clock again and sets `irq_flag`.
- R7: If SDA is high at that ninth rising edge (NACK), the block releases both lines, clears `stat_rw` and `stat_full`, sets no interrupt, and waits for a START.
- R8: An address byte that does not match, or that has R/W = 0, gets no ACK. Both lines stay released until the next START, and neither status nor the interrupt changes.
- R9: A STOP (SDA rising while SCL is high) at any point releases both lines, clears `stat_rw`, and returns the block to waiting for a START.
- R10: `irq_flag` stays 1 until `irq_clr` is pulsed.
- R11: A `rd_buf` pulse clears `stat_full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_addr | input | 7 | Slave address to match |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| txbuf_wr | input | 1 | Write strobe for the transmit buffer and shift register |
| txbuf_wdata | input | 8 | Byte to transmit |
| rel_set | input | 1 | Request to release the stretched clock |
| rd_buf | input | 1 | Read strobe for the data buffer, clears buffer-full |
| buf_rdata | output | 8 | Data buffer contents |
| irq_flag | output | 1 | Sticky per-byte interrupt flag |
| irq_clr | input | 1 | Clears the interrupt flag |
| stat_rw | output | 1 | Read request in progress |
| stat_full | output | 1 | Buffer holds an unread address byte |

## Verification
The hardest state to reach from the ports is a STOP in the middle of a data byte. A STOP needs SDA to rise while SCL is high, and the slave can block that by pulling SDA low for a zero bit. The bench gets there by running a matched read, loading the byte 0xFF so the slave never pulls SDA, clocking three bits out, and then issuing the STOP. The bench's master model also waits for SCL to rise on the wired-AND bus, so a stretched clock stalls it the same way it would stall a real master. The bench also releases the clock after a second ACKed byte without writing new data, to show the release is refused on every byte and not just the first.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_HOLD,
      ST_TX,
      ST_TACK,
      ST_SKIP
   } i2cs_state_e;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '1;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  =  scl_s & ~scl_q;
   assign scl_fall  = ~scl_s &  scl_q;
   assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
   assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/i2cs_top.sv
module i2cs_top
   import i2cs_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              scl_oe,
   output logic              sda_oe,
   input  logic              txbuf_wr,
   input  logic [DATA_W-1:0] txbuf_wdata,
   input  logic              rel_set,
   input  logic              rd_buf,
   output logic [DATA_W-1:0] buf_rdata,
   output logic              irq_flag,
   input  logic              irq_clr,
   output logic              stat_rw,
   output logic              stat_full
);
   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

   generate
      if (ADDR_W != DATA_W - 1) begin : g_bad_addr_w
         $error("ADDR_W must be DATA_W-1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic scl_s, sda_s;
   logic scl_rise, scl_fall, start_det, stop_det;

   i2cs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_in, sda_in}),
      .q     ({scl_s, sda_s})
   );

   i2cs_cond u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2cs_state_e       st;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] rx_sh, tx_sh, buf_q;
   logic              loaded, irq_q, rw_q, full_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         cnt    <= '0;
         rx_sh  <= '0;
         tx_sh  <= '0;
         buf_q  <= '0;
         loaded <= 1'b0;
         irq_q  <= 1'b0;
         rw_q   <= 1'b0;
         full_q <= 1'b0;
      end else begin
         if (txbuf_wr) begin
            buf_q  <= txbuf_wdata;
            tx_sh  <= txbuf_wdata;
            loaded <= 1'b1;
         end
         if (rd_buf)  full_q <= 1'b0;
         if (irq_clr) irq_q  <= 1'b0;

         if (stop_det) begin
            st   <= ST_IDLE;
            rw_q <= 1'b0;
         end else if (start_det) begin
            st  <= ST_ADDR;
            cnt <= '0;
         end else begin
            unique case (st)
               ST_ADDR: begin
                  if (scl_rise && cnt != LAST_BIT) begin
                     rx_sh <= {rx_sh[DATA_W-2:0], sda_s};
                     cnt   <= cnt + CNT_W'(1);
                  end else if (scl_fall && cnt == LAST_BIT) begin
                     if (rx_sh[DATA_W-1:1] == own_addr && rx_sh[0]) begin
                        st     <= ST_AACK;
                        rw_q   <= 1'b1;
                        buf_q  <= rx_sh;
                        full_q <= 1'b1;
                     end else begin
                        st <= ST_SKIP;
                     end
                  end
               end
               ST_AACK: begin
                  if (scl_fall) begin
                     st     <= ST_HOLD;
                     irq_q  <= 1'b1;
                     loaded <= 1'b0;
                  end
               end
               ST_HOLD: begin
                  if (rel_set && loaded) begin
                     st  <= ST_TX;
                     cnt <= '0;
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     cnt <= cnt + CNT_W'(1);
                  end else if (scl_fall) begin
                     if (cnt == LAST_BIT) st <= ST_TACK;
                     else tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
                  end
               end
               ST_TACK: begin
                  if (scl_rise && sda_s) begin
                     st     <= ST_IDLE;
                     rw_q   <= 1'b0;
                     full_q <= 1'b0;
                  end else if (scl_fall) begin
                     st     <= ST_HOLD;
                     irq_q  <= 1'b1;
                     loaded <= 1'b0;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign scl_oe    = (st == ST_HOLD);
   assign sda_oe    = (st == ST_AACK) || (st == ST_TX && !tx_sh[DATA_W-1]);
   assign buf_rdata = buf_q;
   assign irq_flag  = irq_q;
   assign stat_rw   = rw_q;
   assign stat_full = full_q;
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_oe,
   input logic sda_oe,
   input logic irq_flag,
   input logic irq_clr,
   input logic stat_full,
   input logic stat_rw,
   input logic scl_fall,
   input logic stop_det,
   input logic rel_set,
   input logic loaded
);
   // R2
   full_with_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_full) |-> stat_rw);

   // R3
   irq_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flag) |-> $past(scl_fall));

   // R3
   hold_sda_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scl_oe |-> !sda_oe);

   // R4
   hold_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_oe && rel_set && !loaded) |=> scl_oe);

   // R9
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (!scl_oe && !sda_oe && !stat_rw));

   // R10
   irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && !irq_clr) |=> irq_flag);
endmodule

bind i2cs_top i2cs_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_oe    (scl_oe),
   .sda_oe    (sda_oe),
   .irq_flag  (irq_flag),
   .irq_clr   (irq_clr),
   .stat_full (stat_full),
   .stat_rw   (stat_rw),
   .scl_fall  (scl_fall),
   .stop_det  (stop_det),
   .rel_set   (rel_set),
   .loaded    (loaded)
);

// File: tb/sim_i2cs_top.sv
module sim_i2cs_top;
   localparam int Q = 16;
   localparam logic [6:0] OWN = 7'h5B;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       m_scl = 1'b1, m_sda = 1'b1;
   logic       scl_oe, sda_oe;
   logic       txbuf_wr = 1'b0, rel_set = 1'b0, rd_buf = 1'b0, irq_clr = 1'b0;
   logic [7:0] txbuf_wdata = 8'h00;
   logic [7:0] buf_rdata;
   logic       irq_flag, stat_rw, stat_full;
   logic       scl_bus, sda_bus;

   assign scl_bus = m_scl & ~scl_oe;
   assign sda_bus = m_sda & ~sda_oe;

   i2cs_top u0 (
      .clk(clk), .rst_n(rst_n), .own_addr(OWN),
      .scl_in(scl_bus), .sda_in(sda_bus),
      .scl_oe(scl_oe), .sda_oe(sda_oe),
      .txbuf_wr(txbuf_wr), .txbuf_wdata(txbuf_wdata),
      .rel_set(rel_set), .rd_buf(rd_buf), .buf_rdata(buf_rdata),
      .irq_flag(irq_flag), .irq_clr(irq_clr),
      .stat_rw(stat_rw), .stat_full(stat_full)
   );

   int checks = 0, fails = 0;
   bit done = 0;

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_scl_high();
      while (!scl_bus) @(negedge clk);
   endtask

   task automatic pulse_wr(logic [7:0] d);
      @(negedge clk); txbuf_wdata = d; txbuf_wr = 1'b1;
      @(negedge clk); txbuf_wr = 1'b0;
   endtask

   task automatic pulse_rel();
      @(negedge clk); rel_set = 1'b1;
      @(negedge clk); rel_set = 1'b0;
   endtask

   task automatic pulse_irq_clr();
      @(negedge clk); irq_clr = 1'b1;
      @(negedge clk); irq_clr = 1'b0;
   endtask

   task automatic pulse_rd();
      @(negedge clk); rd_buf = 1'b1;
      @(negedge clk); rd_buf = 1'b0;
   endtask

   task automatic bus_start();
      m_sda = 1'b1; m_scl = 1'b1; idle(Q);
      m_sda = 1'b0; idle(Q);
      m_scl = 1'b0; idle(Q);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; idle(Q);
      m_scl = 1'b1; wait_scl_high(); idle(Q);
      m_sda = 1'b1; idle(Q);
   endtask

   task automatic send_bit(logic b);
      m_sda = b; idle(Q);
      m_scl = 1'b1; wait_scl_high(); idle(Q);
      m_scl = 1'b0; idle(Q);
   endtask

   task automatic recv_bit(output logic b);
      m_sda = 1'b1; idle(Q);
      m_scl = 1'b1; wait_scl_high(); idle(Q / 2);
      b = sda_bus; idle(Q / 2);
      m_scl = 1'b0; idle(Q);
   endtask

   task automatic send_byte(logic [7:0] d, output logic ack);
      for (int i = 7; i >= 0; i--) send_bit(d[i]);
      recv_bit(ack);
   endtask

   task automatic recv_byte(output logic [7:0] d);
      for (int i = 7; i >= 0; i--) recv_bit(d[i]);
   endtask

   task automatic t_reset();
      idle(5);
      check("R1 scl_oe", scl_oe, 0);
      check("R1 sda_oe", sda_oe, 0);
      check("R1 irq", irq_flag, 0);
      check("R1 rw", stat_rw, 0);
      check("R1 full", stat_full, 0);
   endtask

   task automatic t_mismatch();
      logic ack; logic [7:0] d;
      bus_start();
      send_byte({7'h2A, 1'b1}, ack);
      check("R8 mismatch no ack", ack, 1);
      recv_byte(d);
      check("R8 mismatch sda free", d, 8'hFF);
      check("R8 mismatch scl free", scl_oe, 0);
      check("R8 mismatch irq", irq_flag, 0);
      check("R8 mismatch full", stat_full, 0);
      bus_stop();
   endtask

   task automatic t_write_req();
      logic ack;
      bus_start();
      send_byte({OWN, 1'b0}, ack);
      check("R8 write req no ack", ack, 1);
      check("R8 write req rw", stat_rw, 0);
      check("R8 write req scl", scl_oe, 0);
      bus_stop();
   endtask

   task automatic t_read();
      logic ack; logic [7:0] d;
      bus_start();
      send_byte({OWN, 1'b1}, ack);
      check("R2 ack", ack, 0);
      check("R2 rw", stat_rw, 1);
      check("R2 full", stat_full, 1);
      check("R2 buf", buf_rdata, 8'hB7);
      check("R3 stretch", scl_oe, 1);
      check("R3 irq", irq_flag, 1);
      idle(40);
      check("R10 irq sticky", irq_flag, 1);
      check("R3 still stretched", scl_oe, 1);
      pulse_rel(); idle(4);
      check("R4 release w/o data", scl_oe, 1);
      pulse_irq_clr(); idle(2);
      check("R10 irq cleared", irq_flag, 0);
      pulse_rd(); idle(2);
      check("R11 full cleared", stat_full, 0);
      pulse_wr(8'hA5); pulse_rel(); idle(4);
      check("R5 released", scl_oe, 0);
      recv_byte(d);
      check("R5 data A5", d, 8'hA5);
      send_bit(1'b0);
      check("R6 re-stretch", scl_oe, 1);
      check("R6 irq", irq_flag, 1);
      pulse_irq_clr();
      pulse_rel(); idle(4);
      check("R4 second byte w/o data", scl_oe, 1);
      pulse_wr(8'h3C); pulse_rel(); idle(4);
      recv_byte(d);
      check("R5 data 3C", d, 8'h3C);
      send_bit(1'b1);
      check("R7 scl free", scl_oe, 0);
      check("R7 sda free", sda_oe, 0);
      check("R7 rw cleared", stat_rw, 0);
      check("R7 no irq", irq_flag, 0);
      bus_stop();
   endtask

   task automatic t_stop_mid();
      logic ack; logic b;
      bus_start();
      send_byte({OWN, 1'b1}, ack);
      check("R9 setup ack", ack, 0);
      pulse_irq_clr();
      pulse_wr(8'hFF); pulse_rel(); idle(4);
      for (int i = 0; i < 3; i++) recv_bit(b);
      check("R9 bit value", b, 1);
      bus_stop();
      check("R9 scl free", scl_oe, 0);
      check("R9 sda free", sda_oe, 0);
      check("R9 rw cleared", stat_rw, 0);
      m_scl = 1'b0; idle(Q);
      check("R9 no drive after stop", scl_oe | sda_oe, 0);
      m_scl = 1'b1; idle(Q);
   endtask

   initial begin
      idle(5);
      rst_n = 1'b1;
      idle(5);
      t_reset();
      t_mismatch();
      t_write_req();
      t_read();
      t_stop_mid();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule